// File: doc/BRIEF.md
# Traffic Light Sequencer with APB Register File

This block steps a single light through green, yellow and red and is set up entirely through a small APB slave. Software writes a control word with an enable bit, two blink selects and a profile bit. It also writes two timer words. Each timer word packs three dwell times of unequal width, one for each phase of the cycle. The profile bit picks which timer word feeds the countdown. The controller samples that choice every time it loads a new phase, so the timing set can be switched while the light is running.

A read-only status register shows the light currently shown. The `lamp_on` output tells whether that light is lit, which matters in the blink modes. Register writes complete in the APB access phase. Read data is captured in the setup phase and presented only during a read access phase.

Top module: `traffic_ctrl_top`

## Requirements
- R1: After reset the control word reads 0, timer set 0 reads 0xCAFE1234, timer set 1 reads 0xFACE5678 and status reads 0 (red).
- R2: Offset 0x0 holds the control word in bits [3:0] (bit 0 enable, bit 1 blink yellow, bit 2 blink red, bit 3 profile), and its upper bits read as zero. Offsets 0x4 and 0x8 hold timer sets 0 and 1 as full 32-bit read/write words.
- R3: Offset 0xC is status: 0 means red, 1 green, 2 yellow, and the value 3 never appears. Writes to it change nothing.
- R4: Reads of any other offset, including misaligned ones, return 0. Writes to them change no register.
- R5: A register is written only when psel, penable and pwrite are all high. prdata is 0 whenever the bus is not in a read access phase.
- R6: While the enable bit is 0, the light is red and lit.
- R7: In run mode (enable 1, both blink bits 0) the light goes green on the first clock edge after run mode is entered. After that it steps green, then yellow, then red, then green again, and it stays lit.
- R8: Timer field [31:20] sets the green dwell, field [7:0] sets the yellow dwell and field [19:8] sets the red dwell. A field value N keeps the light in that phase for N+1 clock cycles.
- R9: Profile 0 takes the dwell times from timer set 0 and profile 1 takes them from timer set 1. The choice, and the timer contents, are read at each phase load.
- R10: With enable and blink red set, the light is red. It starts lit on entry and toggles every (field [7:0] + 1) cycles.
- R11: With enable and blink yellow set and blink red clear, the light is yellow and blinks at the same rate. Blink red wins when both blink bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| light | output | 2 | Current light: 0 red, 1 green, 2 yellow |
| lamp_on | output | 1 | Current light is lit |

## Verification
The bench runs both timing sets and switches the profile while the light is cycling. A design that read the wrong set, or read it at the wrong moment, would hold a phase for the wrong number of cycles. It also swaps the blink bits, including both at once. A wrong priority would blink yellow instead of red, and a missing restart on mode entry would leave the lamp dark or the countdown stale. It writes to status, to unmapped and misaligned offsets, and with a setup phase that has no access phase. A decoder that is too loose would corrupt a register there, or return stale data when it should return zero.

// File: rtl/traffic_pkg.sv
package traffic_pkg;
  parameter int unsigned GRN_LSB = 20;
  parameter int unsigned GRN_W   = 12;
  parameter int unsigned RED_LSB = 8;
  parameter int unsigned RED_W   = 12;
  parameter int unsigned YEL_LSB = 0;
  parameter int unsigned YEL_W   = 8;
  parameter int unsigned CNT_W   = (GRN_W > RED_W) ? ((GRN_W > YEL_W) ? GRN_W : YEL_W)
                                                   : ((RED_W > YEL_W) ? RED_W : YEL_W);

  parameter int unsigned CTL_W    = 4;
  parameter int unsigned CTL_EN   = 0;
  parameter int unsigned CTL_BLY  = 1;
  parameter int unsigned CTL_BLR  = 2;
  parameter int unsigned CTL_PROF = 3;

  typedef enum logic [1:0] {
    LT_RED    = 2'd0,
    LT_GREEN  = 2'd1,
    LT_YELLOW = 2'd2
  } light_e;

  typedef enum logic [1:0] {
    MD_OFF,
    MD_RUN,
    MD_BLINK_RED,
    MD_BLINK_YEL
  } mode_e;

  typedef struct packed {
    logic [CNT_W-1:0] green_n;
    logic [CNT_W-1:0] yellow_n;
    logic [CNT_W-1:0] red_n;
  } dwell_t;

  function automatic mode_e decode_mode(input logic [CTL_W-1:0] c);
    if (!c[CTL_EN])      return MD_OFF;
    else if (c[CTL_BLR]) return MD_BLINK_RED;
    else if (c[CTL_BLY]) return MD_BLINK_YEL;
    else                 return MD_RUN;
  endfunction
endpackage

// File: rtl/traffic_regs.sv
module traffic_regs
  import traffic_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] T0_RST = 32'hCAFE_1234,
  parameter logic [DATA_W-1:0] T1_RST = 32'hFACE_5678
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [1:0]        status_in,
  output logic [DATA_W-1:0] prdata,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DATA_W-1:0] tmr0_o,
  output logic [DATA_W-1:0] tmr1_o
);
  localparam int unsigned NUM_SETS = 2;
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(4 * (NUM_SETS + 1));

  logic wr_acc, rd_setup, rd_acc;
  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] tmr_q [NUM_SETS];
  logic [DATA_W-1:0] rd_mux, rd_hold;

  assign wr_acc   = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign rd_acc   = psel & penable & ~pwrite;

  always_ff @(posedge clk) begin
    if (rst)
      ctl_q <= '0;
    else if (wr_acc && paddr == OFS_CTL)
      ctl_q <= pwdata[CTL_W-1:0];
  end

  for (genvar i = 0; i < NUM_SETS; i++) begin : g_tmr
    localparam logic [ADDR_W-1:0] OFS_T = ADDR_W'(4 * (i + 1));
    localparam logic [DATA_W-1:0] RST_V = (i == 0) ? T0_RST : T1_RST;
    always_ff @(posedge clk) begin
      if (rst)
        tmr_q[i] <= RST_V;
      else if (wr_acc && paddr == OFS_T)
        tmr_q[i] <= pwdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (paddr == OFS_CTL)
      rd_mux = DATA_W'(ctl_q);
    else if (paddr == OFS_STAT)
      rd_mux = DATA_W'(status_in);
    else
      for (int i = 0; i < NUM_SETS; i++)
        if (paddr == ADDR_W'(4 * (i + 1)))
          rd_mux = tmr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_hold <= '0;
    else if (rd_setup)
      rd_hold <= rd_mux;
  end

  assign prdata = rd_acc ? rd_hold : '0;
  assign ctl_o  = ctl_q;
  assign tmr0_o = tmr_q[0];
  assign tmr1_o = tmr_q[1];
endmodule

// File: rtl/traffic_dwell_sel.sv
module traffic_dwell_sel
  import traffic_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] tmr0,
  input  logic [DATA_W-1:0] tmr1,
  input  logic              profile,
  output dwell_t            dwell
);
  logic [DATA_W-1:0] word;

  assign word = profile ? tmr1 : tmr0;

  always_comb begin
    dwell.green_n  = CNT_W'(word[GRN_LSB +: GRN_W]);
    dwell.red_n    = CNT_W'(word[RED_LSB +: RED_W]);
    dwell.yellow_n = CNT_W'(word[YEL_LSB +: YEL_W]);
  end
endmodule

// File: rtl/traffic_seq.sv
module traffic_seq
  import traffic_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mode_e      mode_now,
  input  dwell_t     dwell,
  output logic [1:0] light,
  output logic       lamp
);
  mode_e            mode_q;
  light_e           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lamp_q, lamp_d;
  logic             expired;

  assign expired = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lamp_d = lamp_q;
    if (mode_now != mode_q) begin
      lamp_d = 1'b1;
      unique case (mode_now)
        MD_OFF:       begin st_d = LT_RED;    cnt_d = '0;             end
        MD_RUN:       begin st_d = LT_GREEN;  cnt_d = dwell.green_n;  end
        MD_BLINK_RED: begin st_d = LT_RED;    cnt_d = dwell.yellow_n; end
        default:      begin st_d = LT_YELLOW; cnt_d = dwell.yellow_n; end
      endcase
    end else begin
      unique case (mode_now)
        MD_OFF: begin
          st_d   = LT_RED;
          cnt_d  = '0;
          lamp_d = 1'b1;
        end
        MD_RUN: begin
          lamp_d = 1'b1;
          if (!expired) begin
            cnt_d = cnt_q - 1'b1;
          end else begin
            unique case (st_q)
              LT_GREEN:  begin st_d = LT_YELLOW; cnt_d = dwell.yellow_n; end
              LT_YELLOW: begin st_d = LT_RED;    cnt_d = dwell.red_n;    end
              default:   begin st_d = LT_GREEN;  cnt_d = dwell.green_n;  end
            endcase
          end
        end
        default: begin
          if (!expired) begin
            cnt_d = cnt_q - 1'b1;
          end else begin
            lamp_d = ~lamp_q;
            cnt_d  = dwell.yellow_n;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_OFF;
      st_q   <= LT_RED;
      cnt_q  <= '0;
      lamp_q <= 1'b1;
    end else begin
      mode_q <= mode_now;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lamp_q <= lamp_d;
    end
  end

  assign light = st_q;
  assign lamp  = lamp_q;
endmodule

// File: rtl/traffic_ctrl_top.sv
module traffic_ctrl_top
  import traffic_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] T0_RST = 32'hCAFE_1234,
  parameter logic [DATA_W-1:0] T1_RST = 32'hFACE_5678
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic [1:0]        light,
  output logic              lamp_on
);
  logic [CTL_W-1:0]  ctl_w;
  logic [DATA_W-1:0] tmr0_w, tmr1_w;
  dwell_t            dwell_w;
  mode_e             mode_w;
  logic [1:0]        light_w;

  traffic_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T0_RST(T0_RST), .T1_RST(T1_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .status_in(light_w), .prdata(prdata),
    .ctl_o(ctl_w), .tmr0_o(tmr0_w), .tmr1_o(tmr1_w)
  );

  traffic_dwell_sel #(.DATA_W(DATA_W)) u_sel (
    .tmr0(tmr0_w), .tmr1(tmr1_w), .profile(ctl_w[CTL_PROF]), .dwell(dwell_w)
  );

  assign mode_w = decode_mode(ctl_w);

  traffic_seq u_seq (
    .clk(clk), .rst(rst), .mode_now(mode_w), .dwell(dwell_w),
    .light(light_w), .lamp(lamp_on)
  );

  assign light = light_w;
endmodule

// File: rtl/traffic_ctrl_chk.sv
module traffic_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [DATA_W-1:0] prdata,
  input logic [1:0]        light,
  input logic              lamp_on,
  input logic [3:0]        ctl
);
  logic run_mode;
  assign run_mode = ctl[0] & ~ctl[1] & ~ctl[2];

  a_r3_status_legal: assert property (@(posedge clk) disable iff (rst)
    light != 2'd3);

  a_r5_rdata_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable && !pwrite) |-> prdata == '0);

  a_r6_off_holds_red: assert property (@(posedge clk) disable iff (rst)
    !ctl[0] |=> (light == 2'd0 && lamp_on));

  a_r7_step_order: assert property (@(posedge clk) disable iff (rst)
    (run_mode && $past(run_mode)) |=>
      (lamp_on && (light == $past(light) ||
       ($past(light) == 2'd1 && light == 2'd2) ||
       ($past(light) == 2'd2 && light == 2'd0) ||
       ($past(light) == 2'd0 && light == 2'd1))));

  a_r10_blink_red: assert property (@(posedge clk) disable iff (rst)
    (ctl[0] && ctl[2]) |=> light == 2'd0);

  a_r11_blink_yellow: assert property (@(posedge clk) disable iff (rst)
    (ctl[0] && ctl[1] && !ctl[2]) |=> light == 2'd2);
endmodule

bind traffic_ctrl_top traffic_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .prdata(prdata), .light(light), .lamp_on(lamp_on), .ctl(ctl_w)
);

// File: tb/traffic_ctrl_top_test.sv
`timescale 1ns/1ps
module traffic_ctrl_top_test;
  localparam int CLK_P = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  light;
  logic        lamp_on;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  traffic_ctrl_top uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .light(light), .lamp_on(lamp_on)
  );

  // behavioural reference model
  logic [3:0]  m_ctl;
  logic [31:0] m_t0, m_t1;
  int m_light, m_cnt, m_mode;
  bit m_lamp;

  always @(posedge clk) begin
    int md, g, r, y;
    logic [31:0] tw;
    if (rst) begin
      m_ctl = 0; m_t0 = 32'hCAFE_1234; m_t1 = 32'hFACE_5678;
      m_light = 0; m_cnt = 0; m_lamp = 1; m_mode = 0;
    end else begin
      md = !m_ctl[0] ? 0 : (m_ctl[2] ? 2 : (m_ctl[1] ? 3 : 1));
      tw = m_ctl[3] ? m_t1 : m_t0;
      g = int'(tw[31:20]); r = int'(tw[19:8]); y = int'(tw[7:0]);
      if (md != m_mode) begin
        m_lamp = 1;
        case (md)
          0: begin m_light = 0; m_cnt = 0; end
          1: begin m_light = 1; m_cnt = g; end
          2: begin m_light = 0; m_cnt = y; end
          default: begin m_light = 2; m_cnt = y; end
        endcase
      end else if (md == 1) begin
        if (m_cnt > 0) m_cnt--;
        else if (m_light == 1) begin m_light = 2; m_cnt = y; end
        else if (m_light == 2) begin m_light = 0; m_cnt = r; end
        else begin m_light = 1; m_cnt = g; end
      end else if (md >= 2) begin
        if (m_cnt > 0) m_cnt--;
        else begin m_lamp = !m_lamp; m_cnt = y; end
      end
      m_mode = md;
      if (psel && penable && pwrite)
        case (paddr)
          8'h00: m_ctl = pwdata[3:0];
          8'h04: m_t0 = pwdata;
          8'h08: m_t1 = pwdata;
          default: ;
        endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      string tag;
      case (m_mode)
        0: tag = "R6 light off";
        1: tag = "R7 R8 R9 run";
        2: tag = "R10 blink red";
        default: tag = "R11 blink yellow";
      endcase
      chk({light, lamp_on} == {m_light[1:0], m_lamp}, tag,
          {29'd0, light, lamp_on}, {29'd0, m_light[1:0], m_lamp});
    end
  end

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    #1 chk(prdata == 0, "R5 setup phase rdata", prdata, 0);
    @(negedge clk); penable = 1;
    #1 chk(prdata == exp, tag, prdata, exp);
    @(negedge clk); psel = 0; penable = 0;
    #1 chk(prdata == 0, "R5 idle rdata", prdata, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(4);
    rst = 0;
    // R1 reset values
    apb_read(8'h00, 32'h0, "R1 ctl reset");
    apb_read(8'h04, 32'hCAFE_1234, "R1 timer0 reset");
    apb_read(8'h08, 32'hFACE_5678, "R1 timer1 reset");
    apb_read(8'h0C, 32'h0, "R1 status reset");
    // R2 map and widths
    apb_write(8'h04, 32'h0030_0201);
    apb_write(8'h08, 32'h0050_0104);
    apb_read(8'h04, 32'h0030_0201, "R2 timer0 rw");
    apb_read(8'h08, 32'h0050_0104, "R2 timer1 rw");
    apb_write(8'h00, 32'hFFFF_FFF0);
    apb_read(8'h00, 32'h0, "R2 ctl upper bits");
    // R4 unmapped and misaligned
    apb_write(8'h10, 32'h1234_5678);
    apb_write(8'h06, 32'hDEAD_BEEF);
    apb_read(8'h10, 32'h0, "R4 unmapped read");
    apb_read(8'h02, 32'h0, "R4 misaligned read");
    apb_read(8'h04, 32'h0030_0201, "R4 timer0 untouched");
    // R5 setup phase without access must not write
    @(negedge clk); psel = 1; pwrite = 1; paddr = 8'h04; pwdata = 32'hFFFF_FFFF;
    @(negedge clk); psel = 0; pwrite = 0;
    apb_read(8'h04, 32'h0030_0201, "R5 no write without enable");
    // R3 status read-only
    apb_write(8'h0C, 32'h2);
    apb_read(8'h0C, 32'h0, "R3 status write ignored");
    apb_read(8'h00, 32'h0, "R3 ctl untouched");
    // R7 R8 run with profile 0, then profile 1 while running
    apb_write(8'h00, 32'h1);
    idle(40);
    apb_write(8'h00, 32'h9);
    idle(40);
    apb_write(8'h08, 32'h0020_0300);
    idle(30);
    // R11 blink yellow
    apb_write(8'h00, 32'h3);
    idle(30);
    apb_read(8'h0C, 32'h2, "R11 status yellow");
    // R10 blink red, with priority over yellow
    apb_write(8'h00, 32'h7);
    idle(30);
    apb_read(8'h0C, 32'h0, "R10 status red priority");
    apb_write(8'h00, 32'h5);
    idle(20);
    apb_write(8'h00, 32'h1);
    idle(25);
    // R6 disable
    apb_write(8'h00, 32'h8);
    idle(5);
    apb_read(8'h0C, 32'h0, "R6 status red when off");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule